// File: doc/BRIEF.md
# Table-Driven Parallel Stream Reorderer

The block permutes samples across a small bundle of parallel streams, one frame at a time. Every stream carries an 8-bit complex sample (real and imaginary parts). All input streams share one valid strobe and one frame-start strobe. Each sample passes through three table-driven stages in turn. The steering stage picks, on each frame position, which input feeds each internal lane. Each lane then has a gather unit. It stores the current frame in one half of a double buffer while it replays the previous frame from the other half, in an order read from its own address table. The routing stage picks, per frame position and per output, which gather unit drives the output or whether the output stays silent.

The block keeps no timing of its own. Every accepted input beat produces one output beat, two clock edges later, and takes the frame position of that input beat. The output side cannot stall, so a FIFO must follow the block. Tables are loaded through a flat write-only address space. A load goes into a shadow bank and becomes active at the next frame start, so a frame is never processed with a mix of old and new tables. Output frame markers are rebuilt from the position count.

Top module: `rr_reorder_top`

## Requirements
- R1: While reset is held and after it is released, every output valid, start and end flag is low.
- R2: The first complete input frame after reset produces no output. Output begins with the first beat of the next frame.
- R3: With a steering entry of 0, gather tables set to position p at position p, and routing fields set so that output o takes unit o, each output reproduces its own input stream delayed by one frame.
- R4: A steering entry r at position p makes lane k take input (k + r) mod N_LANE at that position. With two lanes, r = 1 swaps them.
- R5: On output position p, gather unit u supplies the sample that its lane captured at position sel_u[p] of the previous frame.
- R6: A routing entry holds one 2-bit field per output, with output o in bits [2o+1:2o]. The low bit picks the gather unit. A high bit of 1 mutes the output, which then holds its valid flag low on that beat.
- R7: The output start flag is high exactly on frame position 0, and the end flag exactly on position FRAME_LEN-1. Both are qualified by that output's valid flag.
- R8: An input beat with the start strobe high sets the frame position to 0, whatever the running count was.
- R9: The write space is flat. Addresses [0,F) hold the steering table, [F(1+u),F(2+u)) hold gather table u, and [F(1+N_LANE),F(2+N_LANE)) hold the routing table. Writes become active at the next frame start. The frame in progress keeps the old tables to its end.
- R10: There is no backpressure. Each input beat after the first frame yields exactly one output beat, and idle input cycles give idle output cycles with the same spacing.
- R11: The output for an input beat sampled at clock edge k appears on the outputs after edge k+2, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Beat valid, shared by all input streams |
| in_sop_i | input | 1 | Frame start, shared by all input streams |
| in_re_i | input | N_LANE*DATA_W | Real parts, one per input stream |
| in_im_i | input | N_LANE*DATA_W | Imaginary parts, one per input stream |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_addr_i | input | ADDR_W | Flat table address |
| cfg_wdata_i | input | CFG_DW | Table entry, right-aligned |
| out_valid_o | output | N_LANE | Per-output valid |
| out_sop_o | output | N_LANE | Per-output frame start |
| out_eop_o | output | N_LANE | Per-output frame end |
| out_re_o | output | N_LANE*DATA_W | Real parts, one per output |
| out_im_o | output | N_LANE*DATA_W | Imaginary parts, one per output |

## Verification
A wrong frame position or a swapped buffer half shows as wrong sample values on the very next beat. It also moves the start and end flags off positions 0 and F-1 within that frame. A bank pointer that commits too early or too late shows as a whole frame routed with the wrong tables, and the error is visible from the first beat after the frame start. A wrong fill state shows as output during the first frame, or as no output on the beat that follows the first frame end.

// File: rtl/rr_pkg.sv
package rr_pkg;

  function automatic int rr_max(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // input index that feeds lane `lane` under rotation `rot`
  function automatic int rr_rot_src(int lane, int rot, int n);
    return (lane + rot) % n;
  endfunction

endpackage

// File: rtl/rr_in_stage.sv
module rr_in_stage #(
  parameter int N     = 2,
  parameter int F     = 864,
  parameter int DW    = 8,
  parameter int POS_W = 10,
  parameter int IW    = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic                  sop_i,
  input  logic [N-1:0][DW-1:0]  re_i,
  input  logic [N-1:0][DW-1:0]  im_i,
  input  logic                  act_i,
  input  logic                  pend_i,
  input  logic                  tbl_we_i,
  input  logic [POS_W-1:0]      tbl_addr_i,
  input  logic [IW-1:0]         tbl_data_i,
  output logic                  start_o,
  output logic                  valid_o,
  output logic [POS_W-1:0]      pos_o,
  output logic                  tb_o,
  output logic [N-1:0][DW-1:0]  re_o,
  output logic [N-1:0][DW-1:0]  im_o
);

  localparam logic [POS_W-1:0] LAST = POS_W'(F - 1);

  logic [IW-1:0]        rot_tbl [2][F];
  logic [POS_W-1:0]     cnt_q;
  logic [POS_W-1:0]     pos;
  logic                 tb;
  logic [IW-1:0]        rot;
  logic [N-1:0][DW-1:0] re_sel;
  logic [N-1:0][DW-1:0] im_sel;

  always_comb begin
    pos     = sop_i ? '0 : cnt_q;
    start_o = valid_i && (pos == '0);
    tb      = (start_o && pend_i) ? ~act_i : act_i;
    rot     = rot_tbl[tb][pos];
    for (int k = 0; k < N; k++) begin
      re_sel[k] = re_i[rr_pkg::rr_rot_src(k, int'(rot), N)];
      im_sel[k] = im_i[rr_pkg::rr_rot_src(k, int'(rot), N)];
    end
  end

  // shadow bank write
  always_ff @(posedge clk_i) begin
    if (tbl_we_i) rot_tbl[!act_i][tbl_addr_i] <= tbl_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_o <= 1'b0;
      pos_o   <= '0;
      tb_o    <= 1'b0;
      re_o    <= '0;
      im_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        pos_o <= pos;
        tb_o  <= tb;
        re_o  <= re_sel;
        im_o  <= im_sel;
        cnt_q <= (pos == LAST) ? '0 : pos + 1'b1;
      end
    end
  end

  a_r8_sop_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sop_i) |=> (valid_o && pos_o == '0));

endmodule

// File: rtl/rr_sel_unit.sv
module rr_sel_unit #(
  parameter int F     = 864,
  parameter int DW    = 8,
  parameter int POS_W = 10
) (
  input  logic             clk_i,
  input  logic             valid_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             tb_i,
  input  logic             wb_i,
  input  logic             act_i,
  input  logic [DW-1:0]    re_i,
  input  logic [DW-1:0]    im_i,
  input  logic             tbl_we_i,
  input  logic [POS_W-1:0] tbl_addr_i,
  input  logic [POS_W-1:0] tbl_data_i,
  output logic [DW-1:0]    re_o,
  output logic [DW-1:0]    im_o
);

  logic [2*DW-1:0]  frm_q   [2][F];
  logic [POS_W-1:0] sel_tbl [2][F];
  logic [POS_W-1:0] rd_addr;

  assign rd_addr = sel_tbl[tb_i][pos_i];

  always_ff @(posedge clk_i) begin
    if (tbl_we_i) sel_tbl[!act_i][tbl_addr_i] <= tbl_data_i;
  end

  // capture into half wb_i, replay previous frame from the other half
  always_ff @(posedge clk_i) begin
    if (valid_i) begin
      frm_q[wb_i][pos_i] <= {re_i, im_i};
      {re_o, im_o}       <= frm_q[!wb_i][rd_addr];
    end
  end

endmodule

// File: rtl/rr_out_stage.sv
module rr_out_stage #(
  parameter int N     = 2,
  parameter int F     = 864,
  parameter int DW    = 8,
  parameter int POS_W = 10,
  parameter int IW    = 1,
  parameter int FW    = 2,
  parameter int OW    = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [POS_W-1:0]      pos_i,
  input  logic                  tb_i,
  input  logic                  act_i,
  input  logic [N-1:0][DW-1:0]  re_i,
  input  logic [N-1:0][DW-1:0]  im_i,
  input  logic                  tbl_we_i,
  input  logic [POS_W-1:0]      tbl_addr_i,
  input  logic [OW-1:0]         tbl_data_i,
  output logic [N-1:0]          valid_o,
  output logic [N-1:0]          sop_o,
  output logic [N-1:0]          eop_o,
  output logic [N-1:0][DW-1:0]  re_o,
  output logic [N-1:0][DW-1:0]  im_o
);

  localparam logic [POS_W-1:0] LAST = POS_W'(F - 1);

  logic [OW-1:0] route_tbl [2][F];
  logic [OW-1:0] route;
  logic [IW-1:0] src  [N];
  logic [N-1:0]  live;

  always_comb begin
    route = route_tbl[tb_i][pos_i];
    for (int o = 0; o < N; o++) begin
      src[o]  = route[o*FW +: IW];
      live[o] = valid_i && !route[o*FW + FW - 1] && (int'(src[o]) < N);
    end
  end

  always_ff @(posedge clk_i) begin
    if (tbl_we_i) route_tbl[!act_i][tbl_addr_i] <= tbl_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= '0;
      sop_o   <= '0;
      eop_o   <= '0;
      re_o    <= '0;
      im_o    <= '0;
    end else begin
      for (int o = 0; o < N; o++) begin
        valid_o[o] <= live[o];
        sop_o[o]   <= live[o] && (pos_i == '0);
        eop_o[o]   <= live[o] && (pos_i == LAST);
        if (live[o]) begin
          re_o[o] <= re_i[src[o]];
          im_o[o] <= im_i[src[o]];
        end
      end
    end
  end

  a_r10_idle_gives_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (valid_o == '0));

  for (genvar o = 0; o < N; o++) begin : g_chk
    a_r7_marker_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sop_o[o] || eop_o[o]) |-> valid_o[o]);
    a_r7_sop_eop_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sop_o[o] |-> !eop_o[o]);
  end

endmodule

// File: rtl/rr_reorder_top.sv
module rr_reorder_top #(
  parameter int N_LANE    = 2,
  parameter int FRAME_LEN = 864,
  parameter int DATA_W    = 8,
  localparam int POS_W    = $clog2(FRAME_LEN),
  localparam int IW       = $clog2(N_LANE),
  localparam int FW       = IW + 1,
  localparam int OW       = N_LANE * FW,
  localparam int ADDR_W   = $clog2(FRAME_LEN * (N_LANE + 2) + 1),
  localparam int CFG_DW   = rr_pkg::rr_max(rr_pkg::rr_max(POS_W, OW), IW)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          in_valid_i,
  input  logic                          in_sop_i,
  input  logic [N_LANE-1:0][DATA_W-1:0] in_re_i,
  input  logic [N_LANE-1:0][DATA_W-1:0] in_im_i,
  input  logic                          cfg_we_i,
  input  logic [ADDR_W-1:0]             cfg_addr_i,
  input  logic [CFG_DW-1:0]             cfg_wdata_i,
  output logic [N_LANE-1:0]             out_valid_o,
  output logic [N_LANE-1:0]             out_sop_o,
  output logic [N_LANE-1:0]             out_eop_o,
  output logic [N_LANE-1:0][DATA_W-1:0] out_re_o,
  output logic [N_LANE-1:0][DATA_W-1:0] out_im_o
);

  localparam int F = FRAME_LEN;
  localparam logic [POS_W-1:0]  LAST   = POS_W'(F - 1);
  localparam logic [ADDR_W-1:0] A_SEL0 = ADDR_W'(F);
  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(F * (N_LANE + 1));
  localparam logic [ADDR_W-1:0] A_END  = ADDR_W'(F * (N_LANE + 2));

  // table write decode
  logic               in_we, out_we;
  logic [POS_W-1:0]   in_off, out_off;
  logic [N_LANE-1:0]  sel_we;
  logic [POS_W-1:0]   sel_off [N_LANE];
  logic               any_we;

  assign in_we   = cfg_we_i && (cfg_addr_i < A_SEL0);
  assign in_off  = POS_W'(cfg_addr_i);
  assign out_we  = cfg_we_i && (cfg_addr_i >= A_OUT) && (cfg_addr_i < A_END);
  assign out_off = POS_W'(cfg_addr_i - A_OUT);
  assign any_we  = in_we || out_we || (|sel_we);

  for (genvar u = 0; u < N_LANE; u++) begin : g_dec
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(F * (u + 1));
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(F * (u + 2));
    assign sel_we[u]  = cfg_we_i && (cfg_addr_i >= LO) && (cfg_addr_i < HI);
    assign sel_off[u] = POS_W'(cfg_addr_i - LO);
  end

  // bank / fill state
  logic act_q, pend_q, wb_q, filled_q;
  logic start;

  // stage 1
  logic                          s1_valid, s1_tb;
  logic [POS_W-1:0]              s1_pos;
  logic [N_LANE-1:0][DATA_W-1:0] s1_re, s1_im;

  // stage 2
  logic                          s2_valid_q, s2_tb_q;
  logic [POS_W-1:0]              s2_pos_q;
  logic [N_LANE-1:0][DATA_W-1:0] u_re, u_im;

  rr_in_stage #(
    .N(N_LANE), .F(F), .DW(DATA_W), .POS_W(POS_W), .IW(IW)
  ) i_in (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (in_valid_i),
    .sop_i      (in_sop_i),
    .re_i       (in_re_i),
    .im_i       (in_im_i),
    .act_i      (act_q),
    .pend_i     (pend_q),
    .tbl_we_i   (in_we),
    .tbl_addr_i (in_off),
    .tbl_data_i (cfg_wdata_i[IW-1:0]),
    .start_o    (start),
    .valid_o    (s1_valid),
    .pos_o      (s1_pos),
    .tb_o       (s1_tb),
    .re_o       (s1_re),
    .im_o       (s1_im)
  );

  for (genvar u = 0; u < N_LANE; u++) begin : g_unit
    rr_sel_unit #(
      .F(F), .DW(DATA_W), .POS_W(POS_W)
    ) i_unit (
      .clk_i      (clk_i),
      .valid_i    (s1_valid),
      .pos_i      (s1_pos),
      .tb_i       (s1_tb),
      .wb_i       (wb_q),
      .act_i      (act_q),
      .re_i       (s1_re[u]),
      .im_i       (s1_im[u]),
      .tbl_we_i   (sel_we[u]),
      .tbl_addr_i (sel_off[u]),
      .tbl_data_i (cfg_wdata_i[POS_W-1:0]),
      .re_o       (u_re[u]),
      .im_o       (u_im[u])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= 1'b0;
      pend_q     <= 1'b0;
      wb_q       <= 1'b0;
      filled_q   <= 1'b0;
      s2_valid_q <= 1'b0;
      s2_tb_q    <= 1'b0;
      s2_pos_q   <= '0;
    end else begin
      if (start && pend_q) act_q <= ~act_q;
      if (any_we)               pend_q <= 1'b1;
      else if (start && pend_q) pend_q <= 1'b0;
      if (s1_valid && s1_pos == LAST) begin
        wb_q     <= ~wb_q;
        filled_q <= 1'b1;
      end
      s2_valid_q <= s1_valid && filled_q;
      if (s1_valid) begin
        s2_tb_q  <= s1_tb;
        s2_pos_q <= s1_pos;
      end
    end
  end

  rr_out_stage #(
    .N(N_LANE), .F(F), .DW(DATA_W), .POS_W(POS_W), .IW(IW), .FW(FW), .OW(OW)
  ) i_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (s2_valid_q),
    .pos_i      (s2_pos_q),
    .tb_i       (s2_tb_q),
    .act_i      (act_q),
    .re_i       (u_re),
    .im_i       (u_im),
    .tbl_we_i   (out_we),
    .tbl_addr_i (out_off),
    .tbl_data_i (cfg_wdata_i[OW-1:0]),
    .valid_o    (out_valid_o),
    .sop_o      (out_sop_o),
    .eop_o      (out_eop_o),
    .re_o       (out_re_o),
    .im_o       (out_im_o)
  );

  a_r9_commit_swaps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_q) |-> (act_q != $past(act_q)));
  a_r2_fill_after_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(filled_q) |-> $past(s1_valid && s1_pos == LAST));

endmodule

// File: tb/test_rr_reorder_top.sv
module test_rr_reorder_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 2;
  localparam int F  = 8;
  localparam int DW = 8;
  localparam int AW = $clog2(F * (N + 2) + 1);
  localparam int CW = 4;
  localparam int NVEC = 6;
  // {rot_mode[6:5], sel_mode[4:3], out_mode[2:1], gap[0]}
  localparam logic [6:0] VEC [NVEC] = '{
    {2'd0, 2'd0, 2'd0, 1'b0},
    {2'd1, 2'd0, 2'd0, 1'b0},
    {2'd0, 2'd1, 2'd0, 1'b0},
    {2'd0, 2'd0, 2'd1, 1'b0},
    {2'd0, 2'd2, 2'd2, 1'b0},
    {2'd2, 2'd2, 2'd3, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, cfg_we = 1'b0;
  logic [N-1:0][DW-1:0] in_re = '0, in_im = '0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic [N-1:0] out_valid, out_sop, out_eop;
  logic [N-1:0][DW-1:0] out_re, out_im;

  rr_reorder_top #(.N_LANE(N), .FRAME_LEN(F), .DATA_W(DW)) i_rr_reorder_top (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_sop_i(in_sop),
    .in_re_i(in_re), .in_im_i(in_im), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .out_valid_o(out_valid), .out_sop_o(out_sop),
    .out_eop_o(out_eop), .out_re_o(out_re), .out_im_o(out_im)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  string cur_req = "R1";

  // reference model state
  int in_sh [F], in_ac [F], out_sh [F], out_ac [F];
  int sel_sh [N][F], sel_ac [N][F];
  int cur [N][F], prev [N][F];
  bit pend = 0, filled = 0;
  int cnt = 0, fid = 0;

  bit ex_ok [4];
  bit ex_v [4][N], ex_s [4][N], ex_e [4][N];
  int ex_re [4][N], ex_im [4][N];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%0d exp=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_err++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
      report();
      $finish;
    end
  end

  always @(negedge clk) begin
    int s;
    s = cyc % 4;
    if (ex_ok[s]) begin
      for (int o = 0; o < N; o++) begin
        chk(out_valid[o] == ex_v[s][o], cur_req, "valid", int'(out_valid[o]), int'(ex_v[s][o]));
        chk(out_sop[o] == ex_s[s][o], "R7", "sop", int'(out_sop[o]), int'(ex_s[s][o]));
        chk(out_eop[o] == ex_e[s][o], "R7", "eop", int'(out_eop[o]), int'(ex_e[s][o]));
        if (ex_v[s][o]) begin
          chk(int'(out_re[o]) == ex_re[s][o], cur_req, "re", int'(out_re[o]), ex_re[s][o]);
          chk(int'(out_im[o]) == ex_im[s][o], cur_req, "im", int'(out_im[o]), ex_im[s][o]);
        end
      end
      ex_ok[s] = 1'b0;
    end
  end

  // one cycle of stimulus plus its expected output two edges later
  task automatic drive(bit v, bit s, bit we, int addr, int wd);
    int slot, pos, rot, f, src;
    int smp [N];
    @(negedge clk);
    slot = (cyc + 3) % 4;
    for (int o = 0; o < N; o++) begin
      ex_v[slot][o] = 0; ex_s[slot][o] = 0; ex_e[slot][o] = 0;
      ex_re[slot][o] = 0; ex_im[slot][o] = 0;
    end
    ex_ok[slot] = 1'b1;
    in_valid = v; in_sop = s; cfg_we = we;
    cfg_addr = AW'(addr); cfg_wdata = CW'(wd);
    if (we) begin
      pend = 1;
      if (addr < F) in_sh[addr] = wd;
      else if (addr < F * (N + 1)) sel_sh[addr / F - 1][addr % F] = wd;
      else out_sh[addr - F * (N + 1)] = wd;
    end
    if (!v) begin
      for (int k = 0; k < N; k++) begin in_re[k] = 8'hEE; in_im[k] = 8'h11; end
    end else begin
      pos = s ? 0 : cnt;
      if (pos == 0 && pend) begin
        in_ac = in_sh; out_ac = out_sh; sel_ac = sel_sh; pend = 0;
      end
      for (int k = 0; k < N; k++) begin
        in_re[k] = DW'(fid * 32 + k * 16 + pos + 1);
        in_im[k] = in_re[k] ^ 8'hA5;
      end
      rot = in_ac[pos];
      for (int k = 0; k < N; k++) begin
        src = (k + rot) % N;
        cur[k][pos] = {16'd0, in_re[src], in_im[src]};
      end
      if (filled) begin
        for (int u = 0; u < N; u++) smp[u] = prev[u][sel_ac[u][pos]];
        for (int o = 0; o < N; o++) begin
          f = (out_ac[pos] >> (2 * o)) & 3;
          if ((f & 2) == 0) begin
            ex_v[slot][o] = 1;
            ex_re[slot][o] = (smp[f & 1] >> 8) & 255;
            ex_im[slot][o] = smp[f & 1] & 255;
            ex_s[slot][o] = (pos == 0);
            ex_e[slot][o] = (pos == F - 1);
          end
        end
      end
      if (pos == F - 1) begin prev = cur; filled = 1; fid++; end
      cnt = (pos == F - 1) ? 0 : pos + 1;
    end
  endtask

  function automatic int tv_in(int m, int p);
    return (m == 0) ? 0 : (m == 1) ? 1 : (p % 2);
  endfunction
  function automatic int tv_sel(int m, int p);
    return (m == 0) ? p : (m == 1) ? F - 1 - p : (p + 3) % F;
  endfunction
  // fields: out0 bits[1:0], out1 bits[3:2]; bit0 unit, bit1 mute
  function automatic int tv_out(int m, int p);
    case (m)
      0: return 4'b0100;
      1: return 4'b0001;
      2: return 4'b1001;
      default: return (p % 2 == 0) ? 4'b0100 : 4'b0001;
    endcase
  endfunction
  function automatic string vtag(int i);
    case (i)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3, 4: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic load_tables(int rm, int sm, int om);
    for (int p = 0; p < F; p++) drive(0, 0, 1, p, tv_in(rm, p));
    for (int u = 0; u < N; u++)
      for (int p = 0; p < F; p++) drive(0, 0, 1, F * (u + 1) + p, tv_sel(sm, p));
    for (int p = 0; p < F; p++) drive(0, 0, 1, F * (N + 1) + p, tv_out(om, p));
    drive(0, 0, 0, 0, 0);
  endtask

  task automatic send_frame(int gap);
    for (int p = 0; p < F; p++) begin
      drive(1, p == 0, 0, 0, 0);
      if (gap == 1 && p % 2 == 1) drive(0, 0, 0, 0, 0);
      if (gap == 2) begin drive(0, 0, 0, 0, 0); drive(0, 0, 0, 0, 0); end
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == '0, "R1", "valid in reset", int'(out_valid), 0);
    chk((out_sop | out_eop) == '0, "R1", "markers in reset", int'(out_sop | out_eop), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(out_valid == '0, "R1", "valid after reset", int'(out_valid), 0);

    cur_req = "R3";
    load_tables(0, 0, 0);
    // R8: partial frame then restart; R2: first full frame gives nothing
    cur_req = "R8";
    for (int p = 0; p < 3; p++) drive(1, p == 0, 0, 0, 0);
    cur_req = "R2";
    send_frame(0);
    cur_req = "R3";
    send_frame(0);

    for (int i = 0; i < NVEC; i++) begin
      load_tables(int'(VEC[i][6:5]), int'(VEC[i][4:3]), int'(VEC[i][2:1]));
      cur_req = vtag(i);
      send_frame(int'(VEC[i][0]));
      send_frame(int'(VEC[i][0]));
    end

    // R9: new tables loaded mid-frame stay inactive until next frame start
    load_tables(0, 0, 0);
    send_frame(0);
    cur_req = "R9";
    for (int p = 0; p < 3; p++) drive(1, p == 0, 0, 0, 0);
    load_tables(1, 1, 1);
    for (int p = 3; p < F; p++) drive(1, 0, 0, 0, 0);
    send_frame(0);

    // R11: isolated beats, output exactly two edges after each
    cur_req = "R11";
    send_frame(2);
    repeat (4) drive(0, 0, 0, 0, 0);
    report();
    $finish;
  end

endmodule